// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges each incoming Ethernet frame by its destination address. When a frame's destination is presented with a one-cycle strobe, the filter compares it with the station's own address and classifies it as broadcast, multicast or unicast. It also looks up a 64-entry multicast hash table. Under a 2-bit filter mode it then decides whether the frame is kept. One clock after the strobe it presents the accept decision, the classification flags and a 32-bit fragment of the receive status word with those flags placed where the status consumer expects them.

The hash index comes from a CRC-32 over the destination address. The table bit it selects drives the multicast-filter-match result. While receive is enabled, that selected bit is also captured in a register that software can read.

Top module: `rx_daddr_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to 0 on that edge.
- R2: `result_valid` is high in exactly the cycle after a cycle with `frame_valid` high, and low otherwise.
- R3: `phys_match` is 1 when the strobed destination equals `station_addr`.
- R4: `is_bcast` is 1 when all 48 destination bits are 1. A broadcast frame never has `is_mcast` set.
- R5: `is_mcast` is 1 when bit 40 of `dest_addr` is 1 and the frame is not broadcast. Bit 40 is bit 0 of the first octet, and the first octet is `dest_addr[47:40]`.
- R6: Octets are fed to the hash starting with `dest_addr[47:40]`, each octet least significant bit first. The hash register is reflected CRC-32 with polynomial 0xEDB88320, starts at all ones and is not complemented at the end. The index is bits [31:26] of that register. `mcast_hash_match` = `is_mcast` AND `hash_table[index]`.
- R7: Mode 0 (`filter_mode`=2'b00) accepts only frames with `phys_match`.
- R8: Mode 1 (2'b01) accepts a frame that has `phys_match`, has `is_bcast`, or has `mcast_hash_match`.
- R9: Mode 2 (2'b10) accepts a frame that has `phys_match`, has `is_bcast`, or has `is_mcast`.
- R10: Mode 3 (2'b11) accepts every frame.
- R11: `stat_word` carries `phys_match` at bit 26, `mcast_hash_match` at bit 25, `is_bcast` at bit 20 and `is_mcast` at bit 19. All other bits are 0.
- R12: On a strobe with `rx_en` high, `hash_sel` takes the selected table bit. Otherwise `hash_sel` keeps its value.
- R13: Without a strobe, `accept` and the classification flags keep the values of the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enabled; allows capture of the hash select bit |
| frame_valid | input | 1 | One-cycle strobe: destination address is present |
| dest_addr | input | 48 | Destination address, first octet in [47:40] |
| station_addr | input | 48 | Station's own address |
| hash_table | input | 64 | Multicast hash table |
| filter_mode | input | 2 | Filter mode 0..3 |
| result_valid | output | 1 | Results of the last strobe are new this cycle |
| accept | output | 1 | Frame is to be kept |
| phys_match | output | 1 | Destination equals station address |
| mcast_hash_match | output | 1 | Multicast frame hit the hash table |
| is_bcast | output | 1 | Broadcast destination |
| is_mcast | output | 1 | Multicast, non-broadcast destination |
| stat_word | output | 32 | Status word fragment with flags in place |
| hash_sel | output | 1 | Captured hash select bit |

## Verification
The bench builds the block with its default parameters: a 48-bit address and a 6-bit hash index selecting among 64 table bits. These values match Ethernet framing, so every flag position and mode rule can be checked at its real width. With the full 64-entry table, a one-hot table and its complement let the bench confirm that a multicast address hits exactly the table bit whose index the bench computes independently.

// File: rtl/rx_daddr_filter_pkg.sv
// Package: shared types and constants for the destination address filter.
// Assumes a 32-bit status word fragment in which the flag positions are fixed
// by the downstream status consumer.
package rx_daddr_filter_pkg;

    typedef enum logic [1:0] {
        FMODE_OWN_ONLY  = 2'b00,
        FMODE_HASH      = 2'b01,
        FMODE_ALL_MCAST = 2'b10,
        FMODE_PROMISC   = 2'b11
    } filt_mode_e;

    localparam int STAT_W        = 32;
    localparam int STAT_PHYS_BIT = 26;
    localparam int STAT_HASH_BIT = 25;
    localparam int STAT_BCST_BIT = 20;
    localparam int STAT_MCST_BIT = 19;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    typedef struct packed {
        logic phys;
        logic hash_hit;
        logic bcast;
        logic mcast;
    } addr_class_t;

endpackage

// File: rtl/rx_daddr_classify.sv
// Module: classifies a destination address as own / broadcast / multicast.
// Assumes the first octet sits in the top byte, with its bit 0 as the group bit.
module rx_daddr_classify #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] own,
    output logic              phys,
    output logic              bcast,
    output logic              mcast
);
    localparam int GROUP_BIT = ADDR_W - 8;

    // Combinational address class decode.
    always_comb begin
        phys  = (dest == own);
        bcast = &dest;
        mcast = dest[GROUP_BIT] & ~bcast;
    end
endmodule

// File: rtl/rx_daddr_hash.sv
// Module: hash index of a destination address via serial CRC-32, unrolled.
// Assumes ADDR_W is a multiple of 8 and the first octet is in the top byte,
// fed least significant bit first; the register is not complemented at the end.
module rx_daddr_hash #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] dest,
    output logic [HASH_W-1:0] index
);
    import rx_daddr_filter_pkg::*;

    localparam int OCTETS = ADDR_W / 8;

    logic [CRC_W-1:0] crc;

    // Unrolled bitwise CRC across all address octets.
    always_comb begin
        logic fb;
        crc = '1;
        for (int o = 0; o < OCTETS; o++) begin
            for (int b = 0; b < 8; b++) begin
                fb  = crc[0] ^ dest[ADDR_W - 8*(o+1) + b];
                crc = crc >> 1;
                if (fb) crc = crc ^ CRC_POLY;
            end
        end
        index = crc[CRC_W-1 -: HASH_W];
    end
endmodule

// File: rtl/rx_daddr_decide.sv
// Module: accept decision from the filter mode and the address class.
// Assumes the class flags are already mutually consistent (bcast excludes mcast).
module rx_daddr_decide (
    input  logic                                   [1:0] mode,
    input  rx_daddr_filter_pkg::addr_class_t             cls,
    output logic                                         keep
);
    import rx_daddr_filter_pkg::*;

    filt_mode_e m;

    // Mode-dependent acceptance rule.
    always_comb begin
        m = filt_mode_e'(mode);
        unique case (m)
            FMODE_OWN_ONLY:  keep = cls.phys;
            FMODE_HASH:      keep = cls.phys | cls.bcast | cls.hash_hit;
            FMODE_ALL_MCAST: keep = cls.phys | cls.bcast | cls.mcast;
            default:         keep = 1'b1;
        endcase
    end
endmodule

// File: rtl/rx_daddr_filter.sv
// Module: receive destination address filter, top level.
// Registers classification, accept decision and status fragment one cycle after
// the strobe; captures the selected hash table bit while receive is enabled.
// Assumes frame_valid is a single-cycle strobe with all inputs stable in it.
module rx_daddr_filter #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    frame_valid,
    input  logic [ADDR_W-1:0]       dest_addr,
    input  logic [ADDR_W-1:0]       station_addr,
    input  logic [(1<<HASH_W)-1:0]  hash_table,
    input  logic [1:0]              filter_mode,
    output logic                    result_valid,
    output logic                    accept,
    output logic                    phys_match,
    output logic                    mcast_hash_match,
    output logic                    is_bcast,
    output logic                    is_mcast,
    output logic [31:0]             stat_word,
    output logic                    hash_sel
);
    import rx_daddr_filter_pkg::*;

    localparam int TABLE_N = 1 << HASH_W;

    logic              c_phys, c_bcast, c_mcast, c_keep, c_sel;
    logic [HASH_W-1:0] c_idx;
    addr_class_t       c_cls;
    addr_class_t       r_cls;

    rx_daddr_classify #(.ADDR_W(ADDR_W)) u_classify (
        .dest  (dest_addr),
        .own   (station_addr),
        .phys  (c_phys),
        .bcast (c_bcast),
        .mcast (c_mcast)
    );

    rx_daddr_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
        .dest  (dest_addr),
        .index (c_idx)
    );

    // Table lookup and class bundle.
    always_comb begin
        c_sel          = hash_table[c_idx];
        c_cls.phys     = c_phys;
        c_cls.bcast    = c_bcast;
        c_cls.mcast    = c_mcast;
        c_cls.hash_hit = c_mcast & c_sel;
    end

    rx_daddr_decide u_decide (
        .mode (filter_mode),
        .cls  (c_cls),
        .keep (c_keep)
    );

    // Result register: updates on strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            accept       <= 1'b0;
            r_cls        <= '0;
        end else begin
            result_valid <= frame_valid;
            if (frame_valid) begin
                accept <= c_keep;
                r_cls  <= c_cls;
            end
        end
    end

    // Hash select capture, gated by receive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) hash_sel <= 1'b0;
        else if (frame_valid && rx_en) hash_sel <= c_sel;
    end

    // Output flags and status fragment placement.
    always_comb begin
        phys_match       = r_cls.phys;
        mcast_hash_match = r_cls.hash_hit;
        is_bcast         = r_cls.bcast;
        is_mcast         = r_cls.mcast;
        stat_word                = '0;
        stat_word[STAT_PHYS_BIT] = r_cls.phys;
        stat_word[STAT_HASH_BIT] = r_cls.hash_hit;
        stat_word[STAT_BCST_BIT] = r_cls.bcast;
        stat_word[STAT_MCST_BIT] = r_cls.mcast;
    end

    if (TABLE_N < 2) begin : g_bad_param
        initial $error("HASH_W must be at least 1");
    end
endmodule

// File: rtl/rx_daddr_filter_chk.sv
// Module: protocol checker for rx_daddr_filter, attached through bind.
// Assumes synchronous active-low reset; all properties disabled in reset.
module rx_daddr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       frame_valid,
    input logic [1:0] filter_mode,
    input logic       result_valid,
    input logic       accept,
    input logic       phys_match,
    input logic       mcast_hash_match,
    input logic       is_bcast,
    input logic       is_mcast,
    input logic       hash_sel
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> result_valid);
    assert_result_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !result_valid);
    assert_bcast_not_mcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_bcast |-> !is_mcast);
    assert_hash_needs_mcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mcast_hash_match |-> is_mcast);
    assert_own_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && filter_mode == 2'b00 |=> (accept == phys_match));
    assert_promisc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && filter_mode == 2'b11 |=> accept);
    assert_hash_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && rx_en) |=> $stable(hash_sel));
    assert_flags_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(accept) && $stable(phys_match) && $stable(is_mcast));
endmodule

bind rx_daddr_filter rx_daddr_filter_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_en            (rx_en),
    .frame_valid      (frame_valid),
    .filter_mode      (filter_mode),
    .result_valid     (result_valid),
    .accept           (accept),
    .phys_match       (phys_match),
    .mcast_hash_match (mcast_hash_match),
    .is_bcast         (is_bcast),
    .is_mcast         (is_mcast),
    .hash_sel         (hash_sel)
);

// File: tb/tb_rx_daddr_filter.sv
module tb_rx_daddr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        frame_valid = 1'b0;
    logic [47:0] dest_addr = '0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [63:0] hash_table = '0;
    logic [1:0]  filter_mode = 2'b00;
    logic        result_valid, accept, phys_match, mcast_hash_match;
    logic        is_bcast, is_mcast, hash_sel;
    logic [31:0] stat_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_daddr_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_valid(frame_valid),
        .dest_addr(dest_addr), .station_addr(station_addr),
        .hash_table(hash_table), .filter_mode(filter_mode),
        .result_valid(result_valid), .accept(accept), .phys_match(phys_match),
        .mcast_hash_match(mcast_hash_match), .is_bcast(is_bcast),
        .is_mcast(is_mcast), .stat_word(stat_word), .hash_sel(hash_sel)
    );

    localparam logic [47:0] A_OWN   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] A_OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] A_BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] A_MCAST = 48'h01_00_5E_00_00_01;
    localparam logic [63:0] T_ONES  = '1;
    localparam logic [63:0] T_ZERO  = '0;

    typedef struct packed {
        logic [47:0] dest;
        logic [1:0]  mode;
        logic [63:0] tbl;
        logic        acc;
        logic        phys;
        logic        hhit;
        logic        bc;
        logic        mc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{A_OWN,   2'b00, T_ZERO, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{A_OTHER, 2'b00, T_ONES, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{A_BCAST, 2'b00, T_ONES, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{A_MCAST, 2'b00, T_ONES, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{A_BCAST, 2'b01, T_ZERO, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{A_MCAST, 2'b01, T_ONES, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{A_MCAST, 2'b01, T_ZERO, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{A_OTHER, 2'b01, T_ONES, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{A_OWN,   2'b01, T_ZERO, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{A_MCAST, 2'b10, T_ZERO, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{A_BCAST, 2'b10, T_ONES, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{A_OTHER, 2'b10, T_ONES, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{A_OTHER, 2'b11, T_ZERO, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{A_MCAST, 2'b11, T_ZERO, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench-side hash index: octets first to last, each octet LSB first.
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] oct = a[47 - 8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                if ((r[0] ^ oct[j]) == 1'b1) r = (r >> 1) ^ 32'hEDB8_8320;
                else r = r >> 1;
            end
        end
        return r[31:26];
    endfunction

    // Present one frame on a falling edge; results are sampled one falling edge later.
    task automatic send(input logic [47:0] d, input logic [1:0] m, input logic [63:0] t);
        @(negedge clk);
        dest_addr = d; filter_mode = m; hash_table = t; frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [5:0]  idx;
        logic [31:0] sw;
        // R1: reset state (reset held with a strobe pending)
        frame_valid = 1'b1; dest_addr = A_OWN; rx_en = 1'b1; hash_table = T_ONES;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {result_valid, accept, phys_match, mcast_hash_match,
              is_bcast, is_mcast, hash_sel}, '0);
        check("R1 reset stat_word", stat_word, '0);
        frame_valid = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: R3 R4 R5 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].dest, VECS[i].mode, VECS[i].tbl);
            check($sformatf("R2 result_valid vec %0d", i), result_valid, 1);
            check($sformatf("R7/R8/R9/R10 accept vec %0d", i), accept, VECS[i].acc);
            check($sformatf("R3 R4 R5 R6 flags vec %0d", i),
                  {phys_match, mcast_hash_match, is_bcast, is_mcast},
                  {VECS[i].phys, VECS[i].hhit, VECS[i].bc, VECS[i].mc});
            sw = '0;
            sw[26] = VECS[i].phys; sw[25] = VECS[i].hhit;
            sw[20] = VECS[i].bc;   sw[19] = VECS[i].mc;
            check($sformatf("R11 stat_word vec %0d", i), stat_word, sw);
        end

        // R2: pulse ends one cycle later
        @(negedge clk);
        check("R2 result_valid drops", result_valid, 0);

        // R13: inputs change without strobe, flags hold (last vector: accept=1, mcast=1)
        dest_addr = A_OTHER; filter_mode = 2'b00; hash_table = T_ZERO;
        repeat (3) @(negedge clk);
        check("R13 hold accept", accept, 1);
        check("R13 hold flags", {phys_match, is_bcast, is_mcast}, 3'b001);

        // R6: exact hash index, one-hot table and its complement
        idx = ref_index(A_MCAST);
        send(A_MCAST, 2'b01, 64'd1 << idx);
        check("R6 one-hot hit accept", accept, 1);
        check("R6 one-hot hit match", mcast_hash_match, 1);
        send(A_MCAST, 2'b01, ~(64'd1 << idx));
        check("R6 complement miss accept", accept, 0);
        check("R6 complement miss match", mcast_hash_match, 0);
        idx = ref_index(48'h33_33_00_00_00_FB);
        send(48'h33_33_00_00_00_FB, 2'b01, 64'd1 << idx);
        check("R6 second address hit", mcast_hash_match, 1);

        // R12: capture only with rx_en
        rx_en = 1'b1;
        idx = ref_index(A_MCAST);
        send(A_MCAST, 2'b00, 64'd1 << idx);
        check("R12 capture with rx_en", hash_sel, 1);
        rx_en = 1'b0;
        send(A_MCAST, 2'b00, T_ZERO);
        check("R12 hold without rx_en", hash_sel, 1);
        rx_en = 1'b1;
        send(A_MCAST, 2'b00, T_ZERO);
        check("R12 capture zero", hash_sel, 0);
        rx_en = 1'b0;

        // R1: reset mid-operation after an accepting frame
        send(A_OWN, 2'b00, T_ONES);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {accept, phys_match, stat_word}, '0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule